// File: doc/BRIEF.md
# Cache Maintenance Operation Controller

This block performs maintenance sweeps over a small tagged cache whose lines each carry a valid bit and a dirty bit. Software writes a control word that picks a sweep mode and sets a start bit. The start bit reads back as a busy flag for as long as the sweep runs, and it clears by itself when the sweep is done. During a sweep the controller visits the lines in ascending index order. Each dirty line that must be preserved is sent out through a write port with a valid/ready handshake, and the line's state bits are then updated.

While the controller is busy, client accesses are refused: the line-write port and the write-combiner port both hold their grants low. Software therefore need not poll before it hands the cache new work. A one-entry write-combining buffer merges byte-strobed writes to a single address. A separate control bit drains that buffer through the same write port, and the same busy flag reports when the drain has finished. If the drain bit and the start bit are set together, the buffer is drained first and the sweep follows.

Top module: `cmo_ctrl`

## Requirements
- R1: Writing the control word with bit 0 set while idle makes bit 0 of the read-back word (busy) go to 1 from the next cycle. Busy stays 1 until the operation completes and then returns to 0 without any further software write.
- R2: Control word bits 2:1 hold the sweep mode. They read back unchanged on bits 2:1 of the read-back word. A write with bits 0 and 8 both clear only updates the mode and starts nothing.
- R3: Mode 0 (flush) sends every valid dirty line to the write port, then leaves every line invalid and clean.
- R4: Mode 1 (drop) sends nothing to the write port and leaves every line invalid and clean.
- R5: Mode 2 (clean) sends every valid dirty line to the write port. Afterwards no line is dirty, and each line's valid bit, tag and data are unchanged.
- R6: Mode 3 sweeps all lines but issues no writes and changes no line state.
- R7: A line write-back appears on the write port with address {tag, line index} and the line's data. Address and data stay stable while valid is high and ready is low, and the sweep does not advance until ready is seen.
- R8: Lines are visited in ascending index order, one per cycle when no write-back is pending. A sweep that issues no writes keeps busy high for exactly LINES cycles.
- R9: While busy, cl_gnt_o and wc_gnt_o are 0, and client line writes and combiner writes presented during that time have no effect.
- R10: A control write that arrives while busy is ignored. It neither changes the mode nor starts another operation.
- R11: Control bit 8 drains a pending combiner entry to the write port before busy clears. With no entry pending, the drain completes with no write.
- R12: A combiner write to the address already held merges only the bytes whose strobe bits are set. A first write zeroes the unstrobed bytes. A write to a different address while an entry is pending gets wc_gnt_o = 0 and is not taken.
- R13: When bits 8 and 0 are set together, the combiner entry is written first and the line write-backs follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 9 | Control word: bit 0 start, bits 2:1 mode, bit 8 combiner drain |
| ctrl_rdata_o | output | 9 | Read-back: bit 0 busy, bits 2:1 mode, other bits 0 |
| cl_we_i | input | 1 | Client line write: sets the line valid and dirty |
| cl_idx_i | input | IDX_W | Line index for the client write and the state lookup |
| cl_tag_i | input | TAG_W | Tag written with the line |
| cl_data_i | input | DATA_W | Data written with the line |
| cl_gnt_o | output | 1 | Client port accepted (low while busy) |
| cl_valid_o | output | 1 | Valid bit of the line at cl_idx_i |
| cl_dirty_o | output | 1 | Dirty bit of the line at cl_idx_i |
| cl_tag_o | output | TAG_W | Tag of the line at cl_idx_i |
| cl_data_o | output | DATA_W | Data of the line at cl_idx_i |
| wc_we_i | input | 1 | Combiner write strobe |
| wc_addr_i | input | ADDR_W | Combiner write address |
| wc_be_i | input | DATA_W/8 | Combiner byte strobes |
| wc_data_i | input | DATA_W | Combiner write data |
| wc_gnt_o | output | 1 | Combiner write accepted |
| wb_valid_o | output | 1 | Write port request valid |
| wb_ready_i | input | 1 | Write port ready |
| wb_addr_o | output | ADDR_W | Write port address |
| wb_data_o | output | DATA_W | Write port data |

## Verification
The hardest situation to reach from the ports is a control word and client traffic arriving in the middle of a sweep. The bench creates it by holding write-port ready low while the sweep sits on a dirty line, so busy cannot clear. It then presents a line write, a combiner write and a new start with a different mode, and releases ready afterwards. The line state, the mode read-back, the write log and the later combiner activity show that none of those inputs took effect. Ready is also toggled in a sparse pattern during a clean sweep, which stretches each write-back over several cycles, so the hold rule and the ordering rule are exercised under stalls.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  localparam int CTRL_W    = 9;
  localparam int START_BIT = 0;
  localparam int MODE_LO   = 1;
  localparam int WCF_BIT   = 8;

  typedef enum logic [1:0] {
    MODE_FLUSH = 2'd0,
    MODE_DROP  = 2'd1,
    MODE_CLEAN = 2'd2,
    MODE_NOP   = 2'd3
  } cmo_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_WALK  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/cmo_line_store.sv
module cmo_line_store #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_clr_valid_i,
  input  logic              upd_clr_dirty_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic              a_valid_o,
  output logic              a_dirty_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  output logic              b_valid_o,
  output logic              b_dirty_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o
);
  logic              valid_q [LINES];
  logic              dirty_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b1;
          tag_q[i]   <= wr_tag_i;
          data_q[i]  <= wr_data_i;
        end else if (upd_en_i && upd_idx_i == IDX_W'(i)) begin
          if (upd_clr_valid_i) valid_q[i] <= 1'b0;
          if (upd_clr_dirty_i) dirty_q[i] <= 1'b0;
        end
      end
    end
  end

  assign a_valid_o = valid_q[a_idx_i];
  assign a_dirty_o = dirty_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_data_o  = data_q[a_idx_i];
  assign b_valid_o = valid_q[upd_idx_i];
  assign b_dirty_o = dirty_q[upd_idx_i];
  assign b_tag_o   = tag_q[upd_idx_i];
  assign b_data_o  = data_q[upd_idx_i];

  // R9
  client_vs_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && upd_en_i));

  // R5
  clean_keeps_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_clr_valid_i && !wr_en_i) |=> (valid_q[$past(upd_idx_i)] == $past(b_valid_o)));
endmodule

// File: rtl/cmo_wc_buf.sv
module cmo_wc_buf #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic              gnt_o,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, merged;
  logic              acc;

  assign gnt_o = !busy_i && (!pend_q || addr_i == addr_q);
  assign acc   = we_i && gnt_o;

  always_comb begin
    for (int b = 0; b < BE_W; b++) begin
      if (be_i[b])     merged[b*8 +: 8] = data_i[b*8 +: 8];
      else if (pend_q) merged[b*8 +: 8] = data_q[b*8 +: 8];
      else             merged[b*8 +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end else if (acc) begin
      pend_q <= 1'b1;
      addr_q <= addr_i;
      data_q <= merged;
    end
  end

  assign pend_o = pend_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  // R11
  drain_vs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && acc));

  // R12
  wc_no_clobber_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && we_i && addr_i != addr_q) |=> $stable(addr_q));
endmodule

// File: rtl/cmo_walker.sv
module cmo_walker
  import cmo_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES),
  parameter int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output cmo_mode_e         mode_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  input  logic              line_valid_i,
  input  logic              line_dirty_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              upd_en_o,
  output logic              upd_clr_valid_o,
  output logic              upd_clr_dirty_o,
  input  logic              wc_pend_i,
  input  logic [ADDR_W-1:0] wc_addr_i,
  input  logic [DATA_W-1:0] wc_data_i,
  output logic              wc_clr_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  input  logic              wb_ready_i
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  walk_st_e         state_q;
  cmo_mode_e        mode_q;
  logic [IDX_W-1:0] idx_q;
  logic             walk_req_q;
  logic             need_wb, adv, drain_go;
  logic             ctrl_unused;

  assign ctrl_unused = ^ctrl_wdata_i[WCF_BIT-1:MODE_LO+2];

  always_comb begin
    need_wb  = line_valid_i && line_dirty_i && (mode_q == MODE_FLUSH || mode_q == MODE_CLEAN);
    adv      = (state_q == ST_WALK) && (!need_wb || wb_ready_i);
    drain_go = (state_q == ST_DRAIN) && (!wc_pend_i || wb_ready_i);
    wb_valid_o = (state_q == ST_DRAIN && wc_pend_i) || (state_q == ST_WALK && need_wb);
    wb_addr_o  = (state_q == ST_DRAIN) ? wc_addr_i : {line_tag_i, idx_q};
    wb_data_o  = (state_q == ST_DRAIN) ? wc_data_i : line_data_i;
    upd_en_o        = adv && (mode_q != MODE_NOP);
    upd_clr_valid_o = (mode_q == MODE_FLUSH) || (mode_q == MODE_DROP);
    upd_clr_dirty_o = (mode_q != MODE_NOP);
    wc_clr_o        = (state_q == ST_DRAIN) && wc_pend_i && wb_ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_FLUSH;
      idx_q      <= '0;
      walk_req_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ctrl_we_i) begin
          mode_q     <= cmo_mode_e'(ctrl_wdata_i[MODE_LO+1:MODE_LO]);
          walk_req_q <= ctrl_wdata_i[START_BIT];
          idx_q      <= '0;
          if (ctrl_wdata_i[WCF_BIT])        state_q <= ST_DRAIN;
          else if (ctrl_wdata_i[START_BIT]) state_q <= ST_WALK;
        end
        ST_DRAIN: if (drain_go) state_q <= walk_req_q ? ST_WALK : ST_IDLE;
        ST_WALK: if (adv) begin
          if (idx_q == LAST_IDX) state_q <= ST_IDLE;
          else                   idx_q   <= idx_q + IDX_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign busy_o = (state_q != ST_IDLE);
  assign idx_o  = idx_q;

  // R1
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK && adv && idx_q == LAST_IDX) |=> !busy_o);

  // R10
  busy_ctrl_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl_we_i) |=> $stable(mode_q));

  // R8
  walk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK && adv && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R7
  walk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK && !adv) |=> ($stable(idx_q) && state_q == ST_WALK));

  // R11
  drain_before_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && wc_pend_i && !wb_ready_i) |=> (busy_o && wc_pend_i));
endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
  import cmo_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              cl_we_i,
  input  logic [IDX_W-1:0]  cl_idx_i,
  input  logic [TAG_W-1:0]  cl_tag_i,
  input  logic [DATA_W-1:0] cl_data_i,
  output logic              cl_gnt_o,
  output logic              cl_valid_o,
  output logic              cl_dirty_o,
  output logic [TAG_W-1:0]  cl_tag_o,
  output logic [DATA_W-1:0] cl_data_o,
  input  logic              wc_we_i,
  input  logic [ADDR_W-1:0] wc_addr_i,
  input  logic [BE_W-1:0]   wc_be_i,
  input  logic [DATA_W-1:0] wc_data_i,
  output logic              wc_gnt_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o
);
  cmo_mode_e         mode;
  logic              busy;
  logic [IDX_W-1:0]  walk_idx;
  logic              l_valid, l_dirty;
  logic [TAG_W-1:0]  l_tag;
  logic [DATA_W-1:0] l_data;
  logic              upd_en, upd_clr_valid, upd_clr_dirty;
  logic              wc_pend, wc_clr;
  logic [ADDR_W-1:0] wc_addr;
  logic [DATA_W-1:0] wc_data;

  assign cl_gnt_o = !busy;

  cmo_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(cl_we_i && !busy), .wr_idx_i(cl_idx_i), .wr_tag_i(cl_tag_i), .wr_data_i(cl_data_i),
    .upd_en_i(upd_en), .upd_idx_i(walk_idx),
    .upd_clr_valid_i(upd_clr_valid), .upd_clr_dirty_i(upd_clr_dirty),
    .a_idx_i(cl_idx_i), .a_valid_o(cl_valid_o), .a_dirty_o(cl_dirty_o),
    .a_tag_o(cl_tag_o), .a_data_o(cl_data_o),
    .b_valid_o(l_valid), .b_dirty_o(l_dirty), .b_tag_o(l_tag), .b_data_o(l_data)
  );

  cmo_wc_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_wc (
    .clk_i, .rst_ni, .busy_i(busy),
    .we_i(wc_we_i), .addr_i(wc_addr_i), .be_i(wc_be_i), .data_i(wc_data_i),
    .clr_i(wc_clr), .gnt_o(wc_gnt_o), .pend_o(wc_pend), .addr_o(wc_addr), .data_o(wc_data)
  );

  cmo_walker #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_walk (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i,
    .mode_o(mode), .busy_o(busy), .idx_o(walk_idx),
    .line_valid_i(l_valid), .line_dirty_i(l_dirty), .line_tag_i(l_tag), .line_data_i(l_data),
    .upd_en_o(upd_en), .upd_clr_valid_o(upd_clr_valid), .upd_clr_dirty_o(upd_clr_dirty),
    .wc_pend_i(wc_pend), .wc_addr_i(wc_addr), .wc_data_i(wc_data), .wc_clr_o(wc_clr),
    .wb_valid_o, .wb_addr_o, .wb_data_o, .wb_ready_i
  );

  always_comb begin
    ctrl_rdata_o                 = '0;
    ctrl_rdata_o[START_BIT]      = busy;
    ctrl_rdata_o[MODE_LO +: 2]   = mode;
  end

  // R7
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o)));
endmodule

// File: tb/cmo_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmo_ctrl_tb_top;
  localparam int L  = 8;
  localparam int TW = 6;
  localparam int DW = 32;
  localparam int IW = 3;
  localparam int AW = TW + IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [8:0]    ctrl_wdata = '0;
  logic [8:0]    ctrl_rdata;
  logic          cl_we = 1'b0;
  logic [IW-1:0] cl_idx = '0;
  logic [TW-1:0] cl_tag = '0;
  logic [DW-1:0] cl_data = '0;
  logic          cl_gnt, cl_valid, cl_dirty;
  logic [TW-1:0] cl_tag_r;
  logic [DW-1:0] cl_data_r;
  logic          wc_we = 1'b0;
  logic [AW-1:0] wc_addr = '0;
  logic [3:0]    wc_be = '0;
  logic [DW-1:0] wc_data = '0;
  logic          wc_gnt;
  logic          wb_valid;
  logic          wb_ready = 1'b1;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  always #10 clk = ~clk;

  cmo_ctrl #(.LINES(L), .TAG_W(TW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .cl_we_i(cl_we), .cl_idx_i(cl_idx), .cl_tag_i(cl_tag), .cl_data_i(cl_data),
    .cl_gnt_o(cl_gnt), .cl_valid_o(cl_valid), .cl_dirty_o(cl_dirty),
    .cl_tag_o(cl_tag_r), .cl_data_o(cl_data_r),
    .wc_we_i(wc_we), .wc_addr_i(wc_addr), .wc_be_i(wc_be), .wc_data_i(wc_data), .wc_gnt_o(wc_gnt),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write-port ready pattern: 0 always, 1 sparse, 2 never
  int rdy_mode = 0;
  int rdy_cnt = 0;
  always @(negedge clk) begin
    rdy_cnt++;
    case (rdy_mode)
      0: wb_ready = 1'b1;
      1: wb_ready = (rdy_cnt % 3 == 0);
      default: wb_ready = 1'b0;
    endcase
  end

  logic [AW-1:0] log_addr [32];
  logic [DW-1:0] log_data [32];
  int            log_n = 0;
  logic          pv = 1'b0, pr = 1'b0;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (pv && !pr) begin
        chk("R7 hold valid", 32'(wb_valid), 32'd1);
        chk("R7 hold addr", 32'(wb_addr), 32'(pa));
        chk("R7 hold data", wb_data, pd);
      end
      if (wb_valid && wb_ready) begin
        if (log_n < 32) begin
          log_addr[log_n] = wb_addr;
          log_data[log_n] = wb_data;
        end
        log_n++;
      end
      pv = wb_valid; pr = wb_ready; pa = wb_addr; pd = wb_data;
    end
  end

  // shadow model
  logic          sh_v [L];
  logic          sh_d [L];
  logic [TW-1:0] sh_t [L];
  logic [DW-1:0] sh_x [L];
  logic [AW-1:0] ex_a [32];
  logic [DW-1:0] ex_d [32];
  int            ex_n = 0;

  task automatic expect_walk(int mode, bit keep);
    if (!keep) ex_n = 0;
    for (int i = 0; i < L; i++) begin
      if (sh_v[i] && sh_d[i] && (mode == 0 || mode == 2)) begin
        ex_a[ex_n] = {sh_t[i], IW'(i)};
        ex_d[ex_n] = sh_x[i];
        ex_n++;
      end
      if (mode <= 1) begin sh_v[i] = 1'b0; sh_d[i] = 1'b0; end
      else if (mode == 2) sh_d[i] = 1'b0;
    end
  endtask

  task automatic compare_log(string req);
    chk({req, " write count"}, 32'(log_n), 32'(ex_n));
    for (int i = 0; i < ex_n && i < log_n; i++) begin
      chk({req, " write addr"}, 32'(log_addr[i]), 32'(ex_a[i]));
      chk({req, " write data"}, log_data[i], ex_d[i]);
    end
  endtask

  task automatic check_lines(string req);
    for (int i = 0; i < L; i++) begin
      cl_idx = IW'(i);
      #1;
      chk({req, " valid"}, 32'(cl_valid), 32'(sh_v[i]));
      chk({req, " dirty"}, 32'(cl_dirty), 32'(sh_d[i]));
      if (sh_v[i]) begin
        chk({req, " tag"}, 32'(cl_tag_r), 32'(sh_t[i]));
        chk({req, " data"}, cl_data_r, sh_x[i]);
      end
    end
  endtask

  task automatic wr_ctrl(logic [8:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic client_write(int idx, logic [TW-1:0] t, logic [DW-1:0] d);
    @(negedge clk);
    cl_we = 1'b1; cl_idx = IW'(idx); cl_tag = t; cl_data = d;
    @(negedge clk);
    cl_we = 1'b0;
    sh_v[idx] = 1'b1; sh_d[idx] = 1'b1; sh_t[idx] = t; sh_x[idx] = d;
  endtask

  task automatic wc_write(logic [AW-1:0] a, logic [3:0] be, logic [DW-1:0] d, output logic g);
    @(negedge clk);
    wc_we = 1'b1; wc_addr = a; wc_be = be; wc_data = d;
    #1 g = wc_gnt;
    @(negedge clk);
    wc_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (ctrl_rdata[0] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_walk(int mode, string req);
    log_n = 0;
    expect_walk(mode, 0);
    wr_ctrl({6'b0, 2'(mode), 1'b1});
    chk({req, " busy set (R1)"}, 32'(ctrl_rdata[0]), 32'd1);
    wait_idle();
    chk({req, " busy cleared (R1)"}, 32'(ctrl_rdata[0]), 32'd0);
    compare_log(req);
    check_lines(req);
  endtask

  task automatic t_reset();
    chk("R1 reset readback", 32'(ctrl_rdata), 32'd0);
    chk("R9 reset cl_gnt", 32'(cl_gnt), 32'd1);
    chk("R7 reset wb_valid", 32'(wb_valid), 32'd0);
    check_lines("R1 reset lines");
  endtask

  task automatic t_mode_readback();
    wr_ctrl(9'b0_0000_0100);
    @(negedge clk);
    chk("R2 mode readback", 32'(ctrl_rdata[2:1]), 32'd2);
    chk("R2 no start", 32'(ctrl_rdata[0]), 32'd0);
  endtask

  task automatic t_nop_timing();
    int n = 0;
    client_write(2, 6'h11, 32'hC0DE_0002);
    client_write(5, 6'h25, 32'hC0DE_0005);
    log_n = 0;
    expect_walk(3, 0);
    wr_ctrl(9'b0_0000_0111);
    while (ctrl_rdata[0] && n < 100) begin n++; @(negedge clk); end
    chk("R8 busy cycles", 32'(n), 32'(L));
    compare_log("R6 nop");
    check_lines("R6 nop lines");
  endtask

  task automatic t_clean_stall();
    client_write(1, 6'h01, 32'h1111_0001);
    client_write(3, 6'h33, 32'h3333_0003);
    client_write(6, 6'h3F, 32'h6666_0006);
    rdy_mode = 1;
    run_walk(2, "R5 clean");
    rdy_mode = 0;
  endtask

  task automatic t_drop();
    client_write(0, 6'h0A, 32'hDEAD_0000);
    run_walk(1, "R4 drop");
  endtask

  task automatic t_flush();
    client_write(0, 6'h02, 32'hAB00_0000);
    client_write(7, 6'h37, 32'hAB00_0007);
    run_walk(2, "R5 pre-clean");
    client_write(3, 6'h13, 32'hAB00_0003);
    run_walk(0, "R3 flush");
  endtask

  task automatic t_busy_ignore();
    logic g;
    client_write(2, 6'h22, 32'h2222_BEEF);
    log_n = 0;
    expect_walk(2, 0);
    rdy_mode = 2;
    wr_ctrl(9'b0_0000_0101);
    repeat (4) @(negedge clk);
    chk("R9 cl_gnt low while busy", 32'(cl_gnt), 32'd0);
    chk("R9 wc_gnt low while busy", 32'(wc_gnt), 32'd0);
    cl_we = 1'b1; cl_idx = 3'd5; cl_tag = 6'h05; cl_data = 32'h5555_5555;
    @(negedge clk);
    cl_we = 1'b0;
    wc_write(9'h0F0, 4'hF, 32'h0BAD_0BAD, g);
    chk("R9 wc write refused", 32'(g), 32'd0);
    wr_ctrl(9'b1_0000_0001);
    rdy_mode = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R10 no restart", 32'(ctrl_rdata[0]), 32'd0);
    chk("R10 mode kept", 32'(ctrl_rdata[2:1]), 32'd2);
    compare_log("R10 single sweep");
    check_lines("R9 stalled write dropped");
  endtask

  task automatic t_combine();
    logic g;
    log_n = 0;
    wc_write(9'h0A5, 4'b0011, 32'hAAAA_1122, g);
    chk("R12 first grant", 32'(g), 32'd1);
    wc_write(9'h0A5, 4'b1100, 32'h3344_BBBB, g);
    chk("R12 same-address grant", 32'(g), 32'd1);
    wc_write(9'h0A6, 4'b1111, 32'hFFFF_FFFF, g);
    chk("R12 other address refused", 32'(g), 32'd0);
    ex_n = 1; ex_a[0] = 9'h0A5; ex_d[0] = 32'h3344_1122;
    wr_ctrl(9'b1_0000_0100);
    wait_idle();
    chk("R11 busy cleared after drain", 32'(ctrl_rdata[0]), 32'd0);
    compare_log("R11 drain");
    log_n = 0; ex_n = 0;
    wr_ctrl(9'b1_0000_0100);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R11 empty drain idle", 32'(ctrl_rdata[0]), 32'd0);
    compare_log("R11 empty drain");
    check_lines("R11 lines untouched");
  endtask

  task automatic t_both();
    logic g;
    wc_write(9'h1C4, 4'b0101, 32'h0077_0088, g);
    chk("R13 wc grant", 32'(g), 32'd1);
    client_write(4, 6'h2C, 32'h4444_0004);
    log_n = 0; ex_n = 1; ex_a[0] = 9'h1C4; ex_d[0] = 32'h0077_0088;
    expect_walk(2, 1);
    wr_ctrl(9'b1_0000_0101);
    wait_idle();
    compare_log("R13 drain then sweep");
    check_lines("R13 lines");
  endtask

  initial begin
    for (int i = 0; i < L; i++) begin
      sh_v[i] = 1'b0; sh_d[i] = 1'b0; sh_t[i] = '0; sh_x[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_readback();
    t_nop_timing();
    t_clean_stall();
    t_drop();
    t_flush();
    t_busy_ignore();
    t_combine();
    t_both();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule